// File: doc/BRIEF.md
# Acknowledge-Polling Write Completion Master

This block is a two-wire bus master that waits for a serial memory to finish its internal write cycle. The memory ignores the bus while that cycle runs. The master uses this: it repeatedly sends a start condition and a control byte made of the 7-bit device address with a write direction bit. After each byte it reads the acknowledge bit. A high acknowledge bit (no acknowledge) means the memory is still busy. The master then ends that attempt with a stop condition and begins the next attempt at once. A low acknowledge bit means the write has completed, and the master reports done.

Polling may start right after the stop condition that ended the write command. An attempt limit bounds the wait: when every attempt goes unacknowledged, the master reports a timeout. When an attempt is acknowledged, a configuration input chooses what happens to the bus. The master either sends a stop condition, or it keeps the bus with SCL low so that a chained command can follow without a new arbitration. The block generates no data transfers. Its SCL and SDA controls are plain signals, because no data stream passes through it.

Top module: `ack_poll_master`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_low_o` is 0, and `busy_o`, `done_o` and `timeout_o` are all 0.
- R2: A `start_i` pulse is accepted only while `busy_o` is 0. While busy, `start_i` and changes on `dev_addr_i` have no effect on the bus waveform.
- R3: Every attempt begins with a start condition. SDA is pulled low while SCL is high, and SCL then goes low.
- R4: The control byte sent in each attempt is `{dev_addr_i, 1'b0}`, MSB first, where 1 on the bus means SDA is released. During the ninth (acknowledge) clock, SDA is released.
- R5: Every SCL bit slot is four quarter phases, low-high-high-low, and each quarter lasts `QTR_DIV` system clocks. The start and stop slots also have four quarters.
- R6: SDA is sampled at the end of the second high quarter of the acknowledge clock. If it is high, the master sends a stop condition (SDA rises while SCL is high) and then begins a new attempt at once.
- R7: If SDA is low at that sample and `hold_bus_i` was 0 when the start was accepted, the master sends a stop condition and then pulses `done_o`.
- R8: If SDA is low at that sample and `hold_bus_i` was 1 when the start was accepted, no stop is sent. `done_o` pulses, and in idle SCL stays low with SDA released until the next start.
- R9: After `MAX_TRIES` unacknowledged attempts, each closed by its stop, `timeout_o` pulses and `done_o` does not.
- R10: `done_o` and `timeout_o` are single-cycle pulses that never occur together. Each pulse occurs in the first cycle in which `busy_o` is 0 again.
- R11: During the bit slots of an attempt, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin polling |
| dev_addr_i | input | 7 | Device address, captured with the start |
| hold_bus_i | input | 1 | 1: keep the bus after an acknowledge; 0: send a stop. Captured with the start |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_o | output | 1 | SCL level driven by the master |
| sda_low_o | output | 1 | 1 pulls SDA low; 0 releases it (open drain) |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | Pulse: the slave acknowledged |
| timeout_o | output | 1 | Pulse: the attempt limit was reached |

## Verification
The bus outputs come from state registers through combinational logic. The first start quarter therefore appears in the cycle after the edge that accepts `start_i`. Each quarter then lasts exactly `QTR_DIV` cycles, and one attempt takes 44 quarters. `done_o` or `timeout_o` rises in the cycle after the final quarter ends, which is the same cycle in which `busy_o` falls. The reference model builds this whole per-cycle sequence as soon as it issues a start, and it pops one entry per clock. All outputs are compared on the falling edge, midway between active edges. The simulated slave pulls SDA low during the acknowledge clock of the chosen attempt. Separate counts of observed start conditions and result pulses confirm the number of attempts.

// File: rtl/apm_pkg.sv
package apm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP
  } apm_state_e;

  localparam int unsigned ACK_SLOT = 8;
endpackage

// File: rtl/apm_tick_gen.sv
module apm_tick_gen #(
  parameter int unsigned QTR_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (QTR_DIV < 2) ? 1 : $clog2(QTR_DIV);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(QTR_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/apm_try_counter.sv
module apm_try_counter #(
  parameter int unsigned MAX_TRIES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int unsigned TW = $clog2(MAX_TRIES + 1);

  logic [TW-1:0] tries;

  assign last = (tries == TW'(MAX_TRIES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tries <= '0;
    else if (clear) tries <= '0;
    else if (bump)  tries <= tries + 1'b1;
  end
endmodule

// File: rtl/ack_poll_master.sv
module ack_poll_master
  import apm_pkg::*;
#(
  parameter int unsigned QTR_DIV   = 25,
  parameter int unsigned MAX_TRIES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [6:0] dev_addr_i,
  input  logic       hold_bus_i,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_low_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       timeout_o
);
  apm_state_e state;
  logic [1:0] q;
  logic [3:0] bit_idx;
  logic [6:0] addr_q;
  logic       hold_q;
  logic       acked;
  logic       held;
  logic       tick;
  logic       last_try;
  logic [7:0] ctrl_byte;
  logic       accept;
  logic       slot_end;
  logic       nack_bump;

  assign busy_o    = (state != ST_IDLE);
  assign accept    = (state == ST_IDLE) && start_i;
  assign slot_end  = tick && (q == 2'd3);
  assign nack_bump = slot_end && (state == ST_STOP) && !acked;
  assign ctrl_byte = {addr_q, 1'b0};

  apm_tick_gen #(.QTR_DIV(QTR_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_o),
    .tick (tick)
  );

  apm_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(accept),
    .bump (nack_bump),
    .last (last_try)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      q         <= 2'd0;
      bit_idx   <= 4'd0;
      addr_q    <= 7'd0;
      hold_q    <= 1'b0;
      acked     <= 1'b0;
      held      <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      if (accept) begin
        state  <= ST_START;
        q      <= 2'd0;
        addr_q <= dev_addr_i;
        hold_q <= hold_bus_i;
        held   <= 1'b0;
        acked  <= 1'b0;
      end else if (tick) begin
        q <= q + 2'd1;
        if (state == ST_BITS && bit_idx == 4'(ACK_SLOT) && q == 2'd2)
          acked <= ~sda_i;
        if (q == 2'd3) begin
          unique case (state)
            ST_START: begin
              state   <= ST_BITS;
              bit_idx <= 4'd0;
              acked   <= 1'b0;
            end
            ST_BITS: begin
              if (bit_idx != 4'(ACK_SLOT)) begin
                bit_idx <= bit_idx + 4'd1;
              end else if (acked && hold_q) begin
                state  <= ST_IDLE;
                held   <= 1'b1;
                done_o <= 1'b1;
              end else begin
                state <= ST_STOP;
              end
            end
            ST_STOP: begin
              if (acked) begin
                state  <= ST_IDLE;
                done_o <= 1'b1;
              end else if (last_try) begin
                state     <= ST_IDLE;
                timeout_o <= 1'b1;
              end else begin
                state <= ST_START;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    scl_o     = 1'b1;
    sda_low_o = 1'b0;
    unique case (state)
      ST_IDLE: begin
        scl_o = ~held;
      end
      ST_START: begin
        scl_o     = (q != 2'd3);
        sda_low_o = (q != 2'd0);
      end
      ST_BITS: begin
        scl_o = (q == 2'd1) || (q == 2'd2);
        if (bit_idx != 4'(ACK_SLOT))
          sda_low_o = ~ctrl_byte[3'd7 - bit_idx[2:0]];
      end
      ST_STOP: begin
        scl_o     = (q != 2'd0);
        sda_low_o = (q == 2'd0) || (q == 2'd1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/apm_checker.sv
module apm_checker
  import apm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       scl_o,
  input logic       sda_low_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       timeout_o,
  input apm_state_e state,
  input logic [3:0] bit_idx,
  input logic [6:0] addr_q
);
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, timeout_o})); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_TIMEOUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o); // R9

  AST_RESULT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o) |-> !busy_o); // R10

  AST_IDLE_SDA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sda_low_o); // R8

  AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BITS && bit_idx == 4'(ACK_SLOT)) |-> !sda_low_o); // R4

  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BITS && $past(state) == ST_BITS && scl_o && $past(scl_o))
      |-> $stable(sda_low_o)); // R11

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(addr_q)); // R2
endmodule

bind ack_poll_master apm_checker u_apm_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .scl_o    (scl_o),
  .sda_low_o(sda_low_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .timeout_o(timeout_o),
  .state    (state),
  .bit_idx  (bit_idx),
  .addr_q   (addr_q)
);

// File: tb/sim_ack_poll_master.sv
`timescale 1ns/1ps
module sim_ack_poll_master;
  localparam int QD = 3;
  localparam int MT = 4;

  typedef struct packed {
    logic scl;
    logic sda_low;
    logic busy;
    logic done;
    logic tmo;
    logic slave_low;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [6:0] dev_addr_i = 7'h50;
  logic hold_bus_i = 1'b0;
  logic sda_i;
  logic scl_o, sda_low_o, busy_o, done_o, timeout_o;

  exp_t exp_q[$];
  exp_t exp_now;
  bit   m_held = 0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  bit       pend_start = 0;
  bit       poke = 0;
  logic [6:0] pend_addr;
  bit       pend_hold;
  int       pend_busy_n;

  int starts_seen, done_seen, tmo_seen;
  logic prev_scl = 1'b1, prev_sda_low = 1'b0;

  always #2 clk = ~clk;

  assign sda_i = !(sda_low_o || exp_now.slave_low);

  ack_poll_master #(.QTR_DIV(QD), .MAX_TRIES(MT)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dev_addr_i(dev_addr_i),
    .hold_bus_i(hold_bus_i), .sda_i(sda_i), .scl_o(scl_o), .sda_low_o(sda_low_o),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  function automatic exp_t idle_entry();
    exp_t e;
    e = '0;
    e.scl = !m_held;
    return e;
  endfunction

  task automatic push_qtr(input logic scl, input logic sl, input logic slave);
    exp_t e;
    e = '0;
    e.scl = scl; e.sda_low = sl; e.busy = 1'b1; e.slave_low = slave;
    for (int i = 0; i < QD; i++) exp_q.push_back(e);
  endtask

  task automatic push_final(input logic dn, input logic tm);
    exp_t e;
    e = '0;
    e.scl = !m_held; e.done = dn; e.tmo = tm;
    exp_q.push_back(e);
  endtask

  task automatic build_model(input logic [6:0] addr, input bit hold, input int busy_n);
    logic [7:0] cb;
    bit ack_it;
    cb = {addr, 1'b0};
    m_held = 0;
    for (int a = 0; a < MT; a++) begin
      push_qtr(1, 0, 0); push_qtr(1, 1, 0); push_qtr(1, 1, 0); push_qtr(0, 1, 0);
      for (int b = 7; b >= 0; b--) begin
        push_qtr(0, !cb[b], 0); push_qtr(1, !cb[b], 0);
        push_qtr(1, !cb[b], 0); push_qtr(0, !cb[b], 0);
      end
      ack_it = (a >= busy_n);
      push_qtr(0, 0, ack_it); push_qtr(1, 0, ack_it);
      push_qtr(1, 0, ack_it); push_qtr(0, 0, ack_it);
      if (ack_it && hold) begin
        m_held = 1;
        push_final(1, 0);
        return;
      end
      push_qtr(0, 1, 0); push_qtr(1, 1, 0); push_qtr(1, 0, 0); push_qtr(1, 0, 0);
      if (ack_it) begin
        push_final(1, 0);
        return;
      end
    end
    push_final(0, 1);
  endtask

  task automatic chk(input logic act, input logic expv, input string req, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s at t=%0t: actual=%0b expected=%0b", req, what, $time, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk(scl_o,     exp_now.scl,     "R5", "scl_o");
      chk(sda_low_o, exp_now.sda_low, "R4", "sda_low_o");
      chk(busy_o,    exp_now.busy,    "R2", "busy_o");
      chk(done_o,    exp_now.done,    "R7", "done_o");
      chk(timeout_o, exp_now.tmo,     "R9", "timeout_o");
      if (scl_o && prev_scl && !prev_sda_low && sda_low_o) starts_seen++;
      if (done_o) done_seen++;
      if (timeout_o) tmo_seen++;
      prev_scl = scl_o;
      prev_sda_low = sda_low_o;
      if (pend_start && exp_q.size() == 0) begin
        start_i = 1'b1;
        dev_addr_i = pend_addr;
        hold_bus_i = pend_hold;
        build_model(pend_addr, pend_hold, pend_busy_n);
        pend_start = 0;
      end else if (poke && exp_q.size() != 0) begin
        start_i = 1'b1;
        dev_addr_i = ~dev_addr_i;
        hold_bus_i = ~hold_bus_i;
        poke = 0;
      end else begin
        start_i = 1'b0;
      end
      exp_now = (exp_q.size() != 0) ? exp_q.pop_front() : idle_entry();
    end
  end

  task automatic run_op(input logic [6:0] addr, input bit hold, input int busy_n,
                        input bit do_poke, input string tag);
    int want_tries;
    bit want_done;
    @(posedge clk);
    starts_seen = 0; done_seen = 0; tmo_seen = 0;
    pend_addr = addr; pend_hold = hold; pend_busy_n = busy_n;
    pend_start = 1;
    if (do_poke) begin
      repeat (60) @(posedge clk);
      poke = 1;
    end
    do @(posedge clk); while (pend_start || exp_q.size() != 0);
    repeat (3) @(posedge clk);
    want_done  = (busy_n < MT);
    want_tries = want_done ? busy_n + 1 : MT;
    checks++;
    if (starts_seen != want_tries) begin
      errors++;
      $display("FAIL R6 %s attempts: actual=%0d expected=%0d", tag, starts_seen, want_tries);
    end
    checks++;
    if (done_seen != int'(want_done) || tmo_seen != int'(!want_done)) begin
      errors++;
      $display("FAIL R10 %s pulses: actual done=%0d tmo=%0d expected done=%0d tmo=%0d",
               tag, done_seen, tmo_seen, want_done, !want_done);
    end
  endtask

  initial begin
    exp_now = '0;
    exp_now.scl = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs while and right after reset
    chk(scl_o, 1'b1, "R1", "reset scl_o");
    chk(sda_low_o, 1'b0, "R1", "reset sda_low_o");
    chk(busy_o | done_o | timeout_o, 1'b0, "R1", "reset status");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R3/R4/R7: immediate acknowledge, stop afterwards
    run_op(7'h50, 0, 0, 0, "R7 first-try");
    // R6: two busy attempts then acknowledge
    run_op(7'h2B, 0, 2, 0, "R6 retry");
    // R2: start and address poked mid-operation are ignored
    run_op(7'h55, 0, 1, 1, "R2 poke");
    // R8: keep the bus after acknowledge
    run_op(7'h7F, 1, 1, 0, "R8 hold");
    @(negedge clk);
    chk(scl_o, 1'b0, "R8", "held scl_o");
    chk(sda_low_o, 1'b0, "R8", "held sda_low_o");
    // R3: repeated start out of the held state
    run_op(7'h01, 0, 0, 0, "R3 from-held");
    // R9: never acknowledged
    run_op(7'h33, 0, 10, 0, "R9 timeout");
    // R11 is covered by the per-cycle waveform compare of R4/R5
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule